// File: doc/BRIEF.md
# Two-Bit Branch History Predictor

This block is a direction predictor for the fetch stage of a pipelined core. It keeps a table of small per-entry state machines and selects one entry with a few low bits of the program counter. The fetch logic presents the PC of the instruction being fetched on the lookup port and receives a taken or not-taken guess in the same cycle. The guess is only a hint. When a branch resolves later in the pipeline, the resolved PC and the actual outcome come back on the update port, and the selected entry is trained. The table has no tags, so two branches whose PCs share the low bits share one entry. This can cost accuracy but never correctness, because the pipeline always checks the real outcome.

The parameter `MODE` selects one of two entry behaviours. In the hysteresis mode, each entry is a four-state saturating machine. The states are `CTR_STRONG_NT` (00), `CTR_WEAK_NT` (01), `CTR_WEAK_T` (10) and `CTR_STRONG_T` (11). A taken outcome steps one state towards `CTR_STRONG_T` and stays there once reached. A not-taken outcome steps one state towards `CTR_STRONG_NT` and stays there once reached. The prediction is the state's upper bit. In the last-outcome mode, an update writes `CTR_STRONG_T` for taken and `CTR_STRONG_NT` for not taken, so the entry simply remembers the previous outcome. This mode exists as a baseline for comparison. The table depth is 2^`IDX_BITS` entries (1024 by default); the depth of 4096 commonly quoted for such tables is reached by setting `IDX_BITS` to 12.

Top module: `branch_hist_pred`

## Requirements
- R1: After a synchronous reset every entry is in `CTR_STRONG_NT`, so every lookup predicts not taken (`lk_taken` = 0). Reset takes priority over a same-cycle update.
- R2: The entry index is PC bits [IDX_BITS+1:2]. PCs that differ only in bits [1:0], or only above bit IDX_BITS+1, select the same entry.
- R3: In hysteresis mode, a taken update moves `CTR_STRONG_NT`→`CTR_WEAK_NT`→`CTR_WEAK_T`→`CTR_STRONG_T` and stays at `CTR_STRONG_T`. A not-taken update moves in the reverse order and stays at `CTR_STRONG_NT`.
- R4: In hysteresis mode the prediction is state bit 1. Starting from a strong state, one opposite outcome does not change the prediction; two consecutive opposite outcomes do.
- R5: In last-outcome mode, a lookup after an update predicts exactly that update's outcome, so a single misprediction inverts the entry.
- R6: While `up_valid` is 0, the `up_pc` and `up_taken` inputs change no entry.
- R7: If a lookup and an update select the same entry in the same cycle, the lookup returns the state from before the update. The new state is visible from the next cycle on.
- R8: For a loop branch that is taken nine times and then not taken once, repeated, a warmed-up table predicts 8 of 10 correctly in last-outcome mode and 9 of 10 correctly in hysteresis mode.
- R9: An update changes only the entry its own index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | PC presented by the fetch stage for lookup |
| lk_taken | output | 1 | Predicted direction for `lk_pc`, 1 = taken |
| up_valid | input | 1 | Qualifies the update port for this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
The properties assume `lk_pc` may change in any cycle. Where they compare a lookup across two cycles, they only conclude something when `lk_pc` held still, so they make no claim about a PC that moved. The properties also take the indices of both ports to come from the same bit slice. They assume that at most one update arrives per cycle, which the single update port already enforces. The stimulus holds `lk_pc` equal to `up_pc` for whole training runs so those conditions fire often. It also interleaves cycles with `up_valid` low that carry changing `up_pc` and `up_taken` values, and it uses aliasing PCs that differ only outside the index field.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

    // Entry state; bit 1 is the predicted direction.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    // Entry behaviour selected at elaboration.
    typedef enum logic {
        MODE_LAST = 1'b0,
        MODE_HYST = 1'b1
    } pred_mode_e;

endpackage

// File: rtl/bhp_index.sv
module bhp_index #(
    parameter int PC_W     = 32,
    parameter int IDX_BITS = 10
) (
    input  logic [PC_W-1:0]     pc,
    output logic [IDX_BITS-1:0] idx
);

    localparam int LSB = 2;            // word-aligned instructions
    localparam int MSB = IDX_BITS + LSB - 1;

    assign idx = pc[MSB:LSB];

    logic unused_low;
    assign unused_low = ^pc[LSB-1:0];

    generate
        if (PC_W > MSB + 1) begin : g_high
            logic unused_high;
            assign unused_high = ^pc[PC_W-1:MSB+1];
        end
    endgenerate

endmodule

// File: rtl/bhp_next_state.sv
module bhp_next_state
    import bhp_pkg::*;
#(
    parameter pred_mode_e MODE = MODE_HYST
) (
    input  ctr_state_e cur,
    input  logic       taken,
    output ctr_state_e nxt
);

    generate
        if (MODE == MODE_HYST) begin : g_hyst
            always_comb begin
                unique case (cur)
                    CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
                    CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
                    CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
                    CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
                    default:       nxt = CTR_STRONG_NT;
                endcase
            end
        end else begin : g_last
            ctr_state_e unused_cur;
            assign unused_cur = cur;
            always_comb begin
                nxt = taken ? CTR_STRONG_T : CTR_STRONG_NT;
            end
        end
    endgenerate

endmodule

// File: rtl/bhp_table.sv
module bhp_table
    import bhp_pkg::*;
#(
    parameter int IDX_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_BITS-1:0] rd_a_idx,
    output ctr_state_e          rd_a_state,
    input  logic [IDX_BITS-1:0] rd_b_idx,
    output ctr_state_e          rd_b_state,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  ctr_state_e          wr_state
);

    localparam int DEPTH = 1 << IDX_BITS;

    ctr_state_e mem [DEPTH];

    // State register: reset wins over a write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= CTR_STRONG_NT;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_state;
        end
    end

    // Reads see the stored value, i.e. the pre-update state.
    always_comb begin
        rd_a_state = mem[rd_a_idx];
        rd_b_state = mem[rd_b_idx];
    end

endmodule

// File: rtl/branch_hist_pred.sv
module branch_hist_pred
    import bhp_pkg::*;
#(
    parameter int         PC_W     = 32,
    parameter int         IDX_BITS = 10,
    parameter pred_mode_e MODE     = MODE_HYST
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    logic [IDX_BITS-1:0] lk_idx;
    logic [IDX_BITS-1:0] up_idx;
    ctr_state_e          lk_state;
    ctr_state_e          up_state;
    ctr_state_e          up_next;

    bhp_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS)) lk_index_i (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bhp_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS)) up_index_i (
        .pc  (up_pc),
        .idx (up_idx)
    );

    bhp_table #(.IDX_BITS(IDX_BITS)) table_i (
        .clk        (clk),
        .rst        (rst),
        .rd_a_idx   (lk_idx),
        .rd_a_state (lk_state),
        .rd_b_idx   (up_idx),
        .rd_b_state (up_state),
        .wr_en      (up_valid),
        .wr_idx     (up_idx),
        .wr_state   (up_next)
    );

    bhp_next_state #(.MODE(MODE)) next_i (
        .cur   (up_state),
        .taken (up_taken),
        .nxt   (up_next)
    );

    // Output process: direction decoded from the looked-up state.
    always_comb begin
        unique case (lk_state)
            CTR_STRONG_NT, CTR_WEAK_NT: lk_taken = 1'b0;
            CTR_WEAK_T, CTR_STRONG_T:   lk_taken = 1'b1;
            default:                    lk_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/bhp_checker.sv
module bhp_checker
    import bhp_pkg::*;
#(
    parameter int         PC_W     = 32,
    parameter int         IDX_BITS = 10,
    parameter pred_mode_e MODE     = MODE_HYST
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken
);

    logic [IDX_BITS-1:0] c_lk_idx;
    logic [IDX_BITS-1:0] c_up_idx;
    logic                same_entry;

    assign c_lk_idx   = lk_pc[IDX_BITS+1:2];
    assign c_up_idx   = up_pc[IDX_BITS+1:2];
    assign same_entry = up_valid && (c_lk_idx == c_up_idx);

    logic unused_chk;
    assign unused_chk = ^{lk_pc, up_pc};

    // R6 and R9: with no update to the looked-up entry, a held lookup is stable.
    p_hold_unrelated_r9: assert property (@(posedge clk) disable iff (rst)
        (!same_entry) |=> ($stable(lk_pc) -> $stable(lk_taken)));

    generate
        if (MODE == MODE_HYST) begin : g_hyst_props
            // R4: an agreeing taken outcome never turns a taken guess off.
            p_taken_stays_r4: assert property (@(posedge clk) disable iff (rst)
                (same_entry && up_taken && lk_taken) |=> ($stable(lk_pc) -> lk_taken));
            // R3: an agreeing not-taken outcome never turns the guess on.
            p_nt_stays_r3: assert property (@(posedge clk) disable iff (rst)
                (same_entry && !up_taken && !lk_taken) |=> ($stable(lk_pc) -> !lk_taken));
        end else begin : g_last_props
            // R5: the next lookup repeats the last outcome.
            p_last_outcome_r5: assert property (@(posedge clk) disable iff (rst)
                same_entry |=> ($stable(lk_pc) -> (lk_taken == $past(up_taken))));
            // R5: a not-taken outcome always yields a not-taken guess.
            p_last_nt_r5: assert property (@(posedge clk) disable iff (rst)
                (same_entry && !up_taken) |=> ($stable(lk_pc) -> !lk_taken));
        end
    endgenerate

endmodule

bind branch_hist_pred bhp_checker #(
    .PC_W(PC_W), .IDX_BITS(IDX_BITS), .MODE(MODE)
) chk_i (.*);

// File: tb/branch_hist_pred_tb_top.sv
module branch_hist_pred_tb_top;
    import bhp_pkg::*;

    localparam int PC_W  = 32;
    localparam int IB_H  = 10;
    localparam int IB_L  = 4;
    localparam int DEP_H = 1 << IB_H;
    localparam int DEP_L = 1 << IB_L;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] lk_pc = '0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_valid = 1'b0;
    logic            up_taken = 1'b0;
    logic            pred_h;
    logic            pred_l;

    int checks = 0;
    int failures = 0;

    // Reference models: integer levels 0..3 for hysteresis, 0/1 for last outcome.
    int m_h [DEP_H];
    int m_l [DEP_L];

    always #5 clk = ~clk;

    branch_hist_pred #(.PC_W(PC_W), .IDX_BITS(IB_H), .MODE(MODE_HYST)) dut_i (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(pred_h),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    branch_hist_pred #(.PC_W(PC_W), .IDX_BITS(IB_L), .MODE(MODE_LAST)) dut1_i (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(pred_l),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    function automatic int ix_h(logic [PC_W-1:0] pc);
        return int'((pc / 4) % DEP_H);
    endfunction

    function automatic int ix_l(logic [PC_W-1:0] pc);
        return int'((pc / 4) % DEP_L);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEP_H; i++) m_h[i] = 0;
            for (int i = 0; i < DEP_L; i++) m_l[i] = 0;
        end else if (up_valid) begin
            if (up_taken) begin
                if (m_h[ix_h(up_pc)] < 3) m_h[ix_h(up_pc)] = m_h[ix_h(up_pc)] + 1;
                m_l[ix_l(up_pc)] = 1;
            end else begin
                if (m_h[ix_h(up_pc)] > 0) m_h[ix_h(up_pc)] = m_h[ix_h(up_pc)] - 1;
                m_l[ix_l(up_pc)] = 0;
            end
        end
    end

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare both outputs with the models.
    task automatic cyc(logic [PC_W-1:0] lpc, logic uv, logic [PC_W-1:0] upc, logic ut);
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #1;
        if (!rst) begin
            check("R3 model hysteresis", pred_h, m_h[ix_h(lpc)] >= 2);
            check("R5 model last-outcome", pred_l, m_l[ix_l(lpc)] == 1);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; up_valid = 1'b1; up_taken = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; up_valid = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [PC_W-1:0] pa;
        int ok_h;
        int ok_l;
        do_reset();

        // R1: reset state, including an update presented during reset.
        cyc(32'h0, 1'b0, 32'h0, 1'b0);
        check("R1 reset hysteresis", pred_h, 1'b0);
        check("R1 reset last-outcome", pred_l, 1'b0);
        cyc(32'hFFFF_FFFC, 1'b0, 32'h0, 1'b0);
        check("R1 reset high pc", pred_h, 1'b0);

        // R3/R7: train pa taken, lookup and update same entry each cycle.
        pa = 32'h0000_0100;
        cyc(pa, 1'b1, pa, 1'b1);
        check("R7 old value strong-nt", pred_h, 1'b0);
        cyc(pa, 1'b1, pa, 1'b1);
        check("R3 weak-nt predicts nt", pred_h, 1'b0);
        check("R5 last taken", pred_l, 1'b1);
        cyc(pa, 1'b1, pa, 1'b1);
        check("R3 weak-t predicts t", pred_h, 1'b1);
        cyc(pa, 1'b1, pa, 1'b1);
        check("R3 saturate strong-t", pred_h, 1'b1);

        // R4: one not-taken from strong taken keeps taken; second flips.
        cyc(pa, 1'b1, pa, 1'b0);
        check("R4 strong-t before nt", pred_h, 1'b1);
        check("R5 last still taken", pred_l, 1'b1);
        cyc(pa, 1'b1, pa, 1'b0);
        check("R4 one miss keeps taken", pred_h, 1'b1);
        check("R5 one miss inverts", pred_l, 1'b0);
        cyc(pa, 1'b0, pa, 1'b0);
        check("R4 two misses flip", pred_h, 1'b0);

        // R6: invalid updates with changing fields do nothing.
        for (int k = 0; k < 6; k++) cyc(pa, 1'b0, pa + 32'(k * 4), k[0]);
        cyc(pa, 1'b0, 32'h0, 1'b0);
        check("R6 invalid ignored", pred_h, 1'b0);
        check("R6 invalid ignored last", pred_l, 1'b0);

        // R2: aliasing PCs share the entry (state now weak-nt in hysteresis).
        cyc(pa, 1'b1, pa + 32'h3, 1'b1);
        cyc(pa + 32'h2, 1'b0, 32'h0, 1'b0);
        check("R2 low bits alias", pred_h, 1'b1);
        cyc(pa + 32'(DEP_H * 4), 1'b0, 32'h0, 1'b0);
        check("R2 high bits alias", pred_h, 1'b1);

        // R9: neighbouring entry untouched by updates to pa.
        cyc(pa + 32'h4, 1'b1, pa, 1'b1);
        check("R9 neighbour hysteresis", pred_h, 1'b0);
        check("R9 neighbour last", pred_l, 1'b0);

        // R8: loop branch 9 taken then 1 not taken.
        do_reset();
        cyc(32'h0, 1'b0, 32'h0, 1'b0);
        check("R1 second reset", pred_h, 1'b0);
        ok_h = 0; ok_l = 0;
        pa = 32'h0000_2040;
        for (int it = 0; it < 3; it++) begin
            for (int j = 0; j < 10; j++) begin
                logic o;
                o = (j < 9);
                cyc(pa, 1'b1, pa, o);
                if (it == 2) begin
                    if (pred_h == o) ok_h++;
                    if (pred_l == o) ok_l++;
                end
            end
        end
        checks++;
        if (ok_h != 9) begin
            failures++;
            $display("FAIL R8 hysteresis actual=%0d expected=9", ok_h);
        end
        checks++;
        if (ok_l != 8) begin
            failures++;
            $display("FAIL R8 last-outcome actual=%0d expected=8", ok_l);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule